// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits between a DRAM command scheduler and the device command bus. It decides whether one candidate command may go out on the current DRAM clock cycle. The scheduler presents a candidate every cycle: an operation, a bank and a row. The block answers with a combinational issue-allowed flag. A command is issued when the scheduler's valid and the flag are both high at a rising clock edge. Only issued commands update the block's state.

Each bank has its own state machine with four states:
- `BK_IDLE`: no row is open.
- `BK_OPENING`: the row has been activated and the activate-to-column delay is still running.
- `BK_ACTIVE`: the row buffer holds an open row.
- `BK_CLOSING`: the precharge delay is running.

The transitions are:
- `BK_IDLE` to `BK_OPENING` on an issued activate.
- `BK_OPENING` to `BK_ACTIVE` when the activate-to-column timer expires.
- `BK_OPENING` or `BK_ACTIVE` to `BK_CLOSING` on an issued precharge.
- `BK_CLOSING` to `BK_IDLE` when the precharge timer expires.
- `BK_CLOSING` to `BK_OPENING` when an activate is issued on the cycle that timer reaches zero.

Each bank also runs a write-recovery counter. Three pieces of state are shared by all banks: an activate window unit (activate spacing and a rolling four-activate window), a write-to-read turnaround counter, and a pipeline that raises a one-cycle read-data strobe a fixed CAS latency after each issued read. All delays are parameters counted in DRAM clock cycles.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset every bank is closed and every timer has expired. An activate to any bank is allowed at once, read and write are refused, and `rd_valid_o` is low.
- R2: The operation code is 0 = precharge, 1 = activate, 2 = read, 3 = write. `cmd_ok_o` is the decision for the current cycle and never takes an unknown value.
- R3: A read or write is allowed only when its bank has a row open, the row given matches that open row, and at least T_RCD (13) cycles have passed since that bank's activate.
- R4: Two issued activates, to any banks, are at least T_RRD (5) cycles apart.
- R5: Any T_FAW (26) cycle window holds at most ACT_LIMIT (4) activates. The next activate waits until T_FAW cycles after the oldest of the last four.
- R6: An activate to a bank is refused while that bank has a row open, and until T_RP (13) cycles after that bank's precharge.
- R7: A read to any bank waits T_WL + T_BURST + T_WTR (9 + 4 + 7 = 20) cycles after the last issued write to any bank.
- R8: A precharge to a bank waits T_WL + T_BURST + T_WR (9 + 4 + 14 = 27) cycles after the last write to that bank.
- R9: A precharge to a bank with no open row is allowed and changes nothing. It starts no precharge delay, so a following activate to that bank is not held back.
- R10: `rd_valid_o` is high for exactly one cycle, T_CL (13) cycles after each issued read. Back-to-back reads give back-to-back strobes.
- R11: A command presented with `cmd_valid_i` low changes no state. It opens no row and starts no activate spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cmd_valid_i | input | 1 | Scheduler presents a command this cycle |
| cmd_op_i | input | 2 | Operation code (0 precharge, 1 activate, 2 read, 3 write) |
| cmd_bank_i | input | $clog2(NUM_BANKS) | Target bank |
| cmd_row_i | input | ROW_W | Row for activate, read and write |
| cmd_ok_o | output | 1 | Candidate may be issued on this cycle |
| rd_valid_o | output | 1 | Read data strobe, T_CL cycles after an issued read |

## Verification
The vector walk offers each rule its candidate one cycle too early and then on the exact cycle it becomes legal. This separates an off-by-one in any timer from a correct one.

- Activates are swept across several banks. This tells bank-local timing (precharge to activate) apart from the shared rules (activate spacing and the rolling window).
- A write on one bank is followed by a read on another. This tells the shared turnaround apart from per-bank write recovery.
- Directed sequences cover the rest: a precharge to a closed bank, a command with valid low, and single and back-to-back reads for the latency strobe.

// File: rtl/dram_guard_pkg.sv
`timescale 1ns/1ps
package dram_guard_pkg;

    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } dram_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPENING,
        BK_ACTIVE,
        BK_CLOSING
    } bank_state_e;

endpackage

// File: rtl/bank_tracker.sv
`timescale 1ns/1ps
module bank_tracker
    import dram_guard_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int T_RCD  = 13,
    parameter int T_RP   = 13,
    parameter int T_WREC = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  dram_cmd_e        op_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             act_ready_o,
    output logic             is_open_o,
    output logic             col_ready_o,
    output logic             pre_ready_o
);

    localparam int TMAX   = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam int WREC_W = $clog2(T_WREC + 1);
    localparam logic [CNT_W-1:0]  RCD_LOAD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0]  RP_LOAD   = CNT_W'(T_RP - 1);
    localparam logic [WREC_W-1:0] WREC_LOAD = WREC_W'(T_WREC - 1);

    bank_state_e        state_q, state_d;
    logic [CNT_W-1:0]   tmr_q, tmr_d;
    logic [ROW_W-1:0]   row_q, row_d;
    logic [WREC_W-1:0]  wrec_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            tmr_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            row_q   <= row_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        tmr_d   = (tmr_q != '0) ? tmr_q - CNT_W'(1) : tmr_q;
        unique case (state_q)
            BK_IDLE: begin
                if (issue_i && op_i == CMD_ACT) begin
                    state_d = BK_OPENING;
                    tmr_d   = RCD_LOAD;
                    row_d   = row_i;
                end
            end
            BK_OPENING: begin
                if (issue_i && op_i == CMD_PRE) begin
                    state_d = BK_CLOSING;
                    tmr_d   = RP_LOAD;
                end else if (tmr_q == '0) begin
                    state_d = BK_ACTIVE;
                end
            end
            BK_ACTIVE: begin
                if (issue_i && op_i == CMD_PRE) begin
                    state_d = BK_CLOSING;
                    tmr_d   = RP_LOAD;
                end
            end
            BK_CLOSING: begin
                if (issue_i && op_i == CMD_ACT) begin
                    state_d = BK_OPENING;
                    tmr_d   = RCD_LOAD;
                    row_d   = row_i;
                end else if (tmr_q == '0) begin
                    state_d = BK_IDLE;
                end
            end
        endcase
    end

    // write recovery counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrec_q <= '0;
        end else if (issue_i && op_i == CMD_WR) begin
            wrec_q <= WREC_LOAD;
        end else if (wrec_q != '0) begin
            wrec_q <= wrec_q - WREC_W'(1);
        end
    end

    // outputs
    always_comb begin
        act_ready_o = (state_q == BK_IDLE) ||
                      (state_q == BK_CLOSING && tmr_q == '0);
        is_open_o   = (state_q == BK_OPENING) || (state_q == BK_ACTIVE);
        col_ready_o = ((state_q == BK_ACTIVE) ||
                       (state_q == BK_OPENING && tmr_q == '0)) &&
                      (row_q == row_i);
        pre_ready_o = (wrec_q == '0);
    end

endmodule

// File: rtl/act_window.sv
`timescale 1ns/1ps
module act_window #(
    parameter int T_RRD     = 5,
    parameter int T_FAW     = 26,
    parameter int ACT_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_issue_i,
    output logic act_ready_o
);

    localparam int RRD_W = $clog2(T_RRD + 1);
    localparam int FAW_W = $clog2(T_FAW + 1);
    localparam int PTR_W = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;
    localparam logic [RRD_W-1:0] RRD_LOAD = RRD_W'(T_RRD - 1);
    localparam logic [FAW_W-1:0] FAW_LOAD = FAW_W'(T_FAW - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ACT_LIMIT - 1);

    logic [RRD_W-1:0] rrd_q;
    logic [FAW_W-1:0] slot_q [ACT_LIMIT];
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rrd_q <= '0;
            ptr_q <= '0;
        end else if (act_issue_i) begin
            rrd_q <= RRD_LOAD;
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
        end else if (rrd_q != '0) begin
            rrd_q <= rrd_q - RRD_W'(1);
        end
    end

    // one expiry timer per activate of the rolling window, oldest at ptr_q
    for (genvar s = 0; s < ACT_LIMIT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (act_issue_i && ptr_q == PTR_W'(s)) begin
                slot_q[s] <= FAW_LOAD;
            end else if (slot_q[s] != '0) begin
                slot_q[s] <= slot_q[s] - FAW_W'(1);
            end
        end
    end

    assign act_ready_o = (rrd_q == '0) && (slot_q[ptr_q] == '0);

endmodule

// File: rtl/rd_strobe_pipe.sv
`timescale 1ns/1ps
module rd_strobe_pipe #(
    parameter int T_CL = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue_i,
    output logic rd_valid_o
);

    if (T_CL == 1) begin : g_single
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= rd_issue_i;
        end
        assign rd_valid_o = q;
    end else begin : g_shift
        logic [T_CL-1:0] sr_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[T_CL-2:0], rd_issue_i};
        end
        assign rd_valid_o = sr_q[T_CL-1];
    end

endmodule

// File: rtl/dram_cmd_guard.sv
`timescale 1ns/1ps
module dram_cmd_guard
    import dram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int T_RCD     = 13,
    parameter int T_RRD     = 5,
    parameter int T_FAW     = 26,
    parameter int ACT_LIMIT = 4,
    parameter int T_RP      = 13,
    parameter int T_WL      = 9,
    parameter int T_BURST   = 4,
    parameter int T_WTR     = 7,
    parameter int T_WR      = 14,
    parameter int T_CL      = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid_i,
    input  logic [1:0]                   cmd_op_i,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank_i,
    input  logic [ROW_W-1:0]             cmd_row_i,
    output logic                         cmd_ok_o,
    output logic                         rd_valid_o
);

    localparam int BANK_W   = $clog2(NUM_BANKS);
    localparam int WTR_SPAN = T_WL + T_BURST + T_WTR;
    localparam int WREC     = T_WL + T_BURST + T_WR;
    localparam int WTR_W    = $clog2(WTR_SPAN + 1);
    localparam logic [WTR_W-1:0] WTR_LOAD = WTR_W'(WTR_SPAN - 1);

    dram_cmd_e            op;
    logic                 issue;
    logic                 win_ok;
    logic [WTR_W-1:0]     wtr_q;
    logic [NUM_BANKS-1:0] bk_issue, bk_act, bk_open, bk_col, bk_pre;

    assign op    = dram_cmd_e'(cmd_op_i);
    assign issue = cmd_valid_i && cmd_ok_o;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bk_issue[b] = issue && (cmd_bank_i == BANK_W'(b));
        bank_tracker #(
            .ROW_W (ROW_W),
            .T_RCD (T_RCD),
            .T_RP  (T_RP),
            .T_WREC(WREC)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue_i    (bk_issue[b]),
            .op_i       (op),
            .row_i      (cmd_row_i),
            .act_ready_o(bk_act[b]),
            .is_open_o  (bk_open[b]),
            .col_ready_o(bk_col[b]),
            .pre_ready_o(bk_pre[b])
        );
    end

    act_window #(
        .T_RRD    (T_RRD),
        .T_FAW    (T_FAW),
        .ACT_LIMIT(ACT_LIMIT)
    ) u_act_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_issue_i(issue && op == CMD_ACT),
        .act_ready_o(win_ok)
    );

    // shared write-to-read turnaround
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wtr_q <= '0;
        end else if (issue && op == CMD_WR) begin
            wtr_q <= WTR_LOAD;
        end else if (wtr_q != '0) begin
            wtr_q <= wtr_q - WTR_W'(1);
        end
    end

    always_comb begin
        cmd_ok_o = 1'b0;
        unique case (op)
            CMD_PRE: cmd_ok_o = !bk_open[cmd_bank_i] || bk_pre[cmd_bank_i];
            CMD_ACT: cmd_ok_o = bk_act[cmd_bank_i] && win_ok;
            CMD_RD:  cmd_ok_o = bk_col[cmd_bank_i] && (wtr_q == '0);
            CMD_WR:  cmd_ok_o = bk_col[cmd_bank_i];
        endcase
    end

    rd_strobe_pipe #(
        .T_CL(T_CL)
    ) u_rd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue_i(issue && op == CMD_RD),
        .rd_valid_o(rd_valid_o)
    );

endmodule

// File: rtl/dram_cmd_guard_chk.sv
`timescale 1ns/1ps
module dram_cmd_guard_chk #(
    parameter int T_RRD     = 5,
    parameter int T_FAW     = 26,
    parameter int ACT_LIMIT = 4,
    parameter int T_WL      = 9,
    parameter int T_BURST   = 4,
    parameter int T_WTR     = 7,
    parameter int T_CL      = 13
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid_i,
    input logic [1:0] cmd_op_i,
    input logic       cmd_ok_o,
    input logic       rd_valid_o
);

    localparam int PTR_W = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;
    localparam int FILL_W = $clog2(ACT_LIMIT + 1);

    logic act_iss, wr_iss, rd_iss;
    assign act_iss = cmd_valid_i && cmd_ok_o && cmd_op_i == 2'd1;
    assign rd_iss  = cmd_valid_i && cmd_ok_o && cmd_op_i == 2'd2;
    assign wr_iss  = cmd_valid_i && cmd_ok_o && cmd_op_i == 2'd3;

    logic [15:0]       since_act, since_wr, since_rd0;
    logic              rd_seen;
    logic [31:0]       now;
    logic [31:0]       ts [ACT_LIMIT];
    logic [PTR_W-1:0]  ptr;
    logic [FILL_W-1:0] filled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act <= 16'hFFFF;
            since_wr  <= 16'hFFFF;
            since_rd0 <= '0;
            rd_seen   <= 1'b0;
            now       <= '0;
            ptr       <= '0;
            filled    <= '0;
            for (int i = 0; i < ACT_LIMIT; i++) ts[i] <= '0;
        end else begin
            now       <= now + 32'd1;
            since_act <= act_iss ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 16'd1);
            since_wr  <= wr_iss  ? 16'd1 : (since_wr  == 16'hFFFF ? since_wr  : since_wr  + 16'd1);
            if (rd_iss && !rd_seen) begin
                rd_seen   <= 1'b1;
                since_rd0 <= 16'd1;
            end else if (rd_seen && since_rd0 != 16'hFFFF) begin
                since_rd0 <= since_rd0 + 16'd1;
            end
            if (act_iss) begin
                ts[ptr] <= now;
                ptr     <= (ptr == PTR_W'(ACT_LIMIT - 1)) ? '0 : ptr + PTR_W'(1);
                if (filled != FILL_W'(ACT_LIMIT)) filled <= filled + FILL_W'(1);
            end
        end
    end

    p_ok_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(cmd_ok_o));

    p_act_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_iss |-> since_act >= 16'(T_RRD));

    p_act_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_iss && filled == FILL_W'(ACT_LIMIT)) |-> (now - ts[ptr]) >= 32'(T_FAW));

    p_wr_to_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_iss |-> since_wr >= 16'(T_WL + T_BURST + T_WTR));

    p_strobe_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_seen && since_rd0 >= 16'(T_CL)));

endmodule

bind dram_cmd_guard dram_cmd_guard_chk #(
    .T_RRD    (T_RRD),
    .T_FAW    (T_FAW),
    .ACT_LIMIT(ACT_LIMIT),
    .T_WL     (T_WL),
    .T_BURST  (T_BURST),
    .T_WTR    (T_WTR),
    .T_CL     (T_CL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_ok_o   (cmd_ok_o),
    .rd_valid_o (rd_valid_o)
);

// File: tb/test_dram_cmd_guard.sv
`timescale 1ns/1ps
module test_dram_cmd_guard;

    localparam logic [1:0] OP_PRE = 2'd0;
    localparam logic [1:0] OP_ACT = 2'd1;
    localparam logic [1:0] OP_RD  = 2'd2;
    localparam logic [1:0] OP_WR  = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = OP_PRE;
    logic [2:0]  cmd_bank = '0;
    logic [13:0] cmd_row = '0;
    logic        cmd_ok;
    logic        rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dram_cmd_guard i_dram_cmd_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(cmd_valid),
        .cmd_op_i   (cmd_op),
        .cmd_bank_i (cmd_bank),
        .cmd_row_i  (cmd_row),
        .cmd_ok_o   (cmd_ok),
        .rd_valid_o (rd_valid)
    );

    typedef struct packed {
        logic [5:0] gap;
        logic [1:0] op;
        logic [2:0] bank;
        logic [3:0] row;
        logic       ok;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 28;
    // each command lands gap+1 cycles after the previous one
    localparam vec_t VECS [NVEC] = '{
        '{6'd0,  OP_RD,  3'd0, 4'd5, 1'b0, 4'd3},  // R3 bank closed
        '{6'd0,  OP_ACT, 3'd0, 4'd5, 1'b1, 4'd6},  // R6 idle bank opens (c=1)
        '{6'd0,  OP_ACT, 3'd1, 4'd7, 1'b0, 4'd4},  // R4 1 cycle after ACT
        '{6'd2,  OP_ACT, 3'd1, 4'd7, 1'b0, 4'd4},  // R4 4 cycles
        '{6'd0,  OP_ACT, 3'd1, 4'd7, 1'b1, 4'd4},  // R4 5 cycles (c=6)
        '{6'd0,  OP_RD,  3'd0, 4'd5, 1'b0, 4'd3},  // R3 6 after ACT
        '{6'd5,  OP_RD,  3'd0, 4'd5, 1'b0, 4'd3},  // R3 12 after ACT
        '{6'd0,  OP_RD,  3'd0, 4'd5, 1'b1, 4'd3},  // R3 13 after ACT (c=14)
        '{6'd0,  OP_RD,  3'd0, 4'd6, 1'b0, 4'd3},  // R3 wrong row
        '{6'd0,  OP_WR,  3'd1, 4'd7, 1'b0, 4'd3},  // R3 10 after ACT
        '{6'd2,  OP_WR,  3'd1, 4'd7, 1'b1, 4'd3},  // R3 13 after ACT (c=19)
        '{6'd0,  OP_RD,  3'd0, 4'd5, 1'b0, 4'd7},  // R7 1 after WR, other bank
        '{6'd17, OP_RD,  3'd0, 4'd5, 1'b0, 4'd7},  // R7 19 after WR
        '{6'd0,  OP_RD,  3'd0, 4'd5, 1'b1, 4'd7},  // R7 20 after WR (c=39)
        '{6'd0,  OP_PRE, 3'd1, 4'd0, 1'b0, 4'd8},  // R8 21 after WR
        '{6'd4,  OP_PRE, 3'd1, 4'd0, 1'b0, 4'd8},  // R8 26 after WR
        '{6'd0,  OP_PRE, 3'd1, 4'd0, 1'b1, 4'd8},  // R8 27 after WR (c=46)
        '{6'd0,  OP_ACT, 3'd1, 4'd9, 1'b0, 4'd6},  // R6 1 after PRE
        '{6'd10, OP_ACT, 3'd1, 4'd9, 1'b0, 4'd6},  // R6 12 after PRE
        '{6'd0,  OP_ACT, 3'd1, 4'd9, 1'b1, 4'd6},  // R6 13 after PRE (c=59)
        '{6'd4,  OP_ACT, 3'd0, 4'd1, 1'b0, 4'd6},  // R6 bank already open
        '{6'd0,  OP_PRE, 3'd2, 4'd0, 1'b1, 4'd9},  // R9 PRE to closed bank
        '{6'd0,  OP_ACT, 3'd2, 4'd3, 1'b1, 4'd9},  // R9 no precharge delay (c=66)
        '{6'd4,  OP_ACT, 3'd3, 4'd0, 1'b1, 4'd5},  // R5 c=71
        '{6'd4,  OP_ACT, 3'd4, 4'd0, 1'b1, 4'd5},  // R5 c=76, four in window
        '{6'd4,  OP_ACT, 3'd5, 4'd0, 1'b0, 4'd5},  // R5 22 after oldest
        '{6'd2,  OP_ACT, 3'd5, 4'd0, 1'b0, 4'd5},  // R5 25 after oldest
        '{6'd0,  OP_ACT, 3'd5, 4'd0, 1'b1, 4'd5}   // R5 26 after oldest
    };

    task automatic check(input int req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic [1:0] op, input int bank, input int row);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cmd_bank  = 3'(bank);
        cmd_row   = 14'(row);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send(1'b0, OP_PRE, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual finished=0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        send(1'b0, OP_ACT, 0, 0);
        check(1, "ACT after reset", cmd_ok, 1'b1);
        check(1, "rd_valid after reset", rd_valid, 1'b0);
        send(1'b0, OP_RD, 0, 0);
        check(1, "RD after reset", cmd_ok, 1'b0);
        send(1'b0, OP_WR, 3, 0);
        check(1, "WR after reset", cmd_ok, 1'b0);
        send(1'b0, OP_PRE, 5, 0);
        check(1, "PRE after reset", cmd_ok, 1'b1);

        // vector walk
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            idle(int'(VECS[i].gap));
            send(1'b1, VECS[i].op, int'(VECS[i].bank), int'(VECS[i].row));
            check(int'(VECS[i].req), $sformatf("vector %0d", i), cmd_ok, VECS[i].ok);
        end

        // R11: command with valid low leaves no trace
        do_reset();
        send(1'b0, OP_ACT, 0, 2);
        send(1'b1, OP_ACT, 1, 4);
        check(11, "ACT right after unissued ACT", cmd_ok, 1'b1);
        idle(12);
        send(1'b1, OP_RD, 0, 2);
        check(11, "RD to bank never opened", cmd_ok, 1'b0);

        // R10: back-to-back reads, strobes 12 and 13 cycles after the second
        send(1'b1, OP_RD, 1, 4);
        check(3, "RD 14 after ACT", cmd_ok, 1'b1);
        send(1'b1, OP_RD, 1, 4);
        check(3, "second RD", cmd_ok, 1'b1);
        for (int k = 1; k <= 15; k++) begin
            send(1'b0, OP_PRE, 0, 0);
            check(10, $sformatf("pair strobe k=%0d", k), rd_valid, (k == 12 || k == 13));
        end

        // R10: single read, strobe only 13 cycles after it
        send(1'b1, OP_RD, 1, 4);
        check(10, "single RD issued", cmd_ok, 1'b1);
        for (int k = 1; k <= 15; k++) begin
            send(1'b0, OP_PRE, 0, 0);
            check(10, $sformatf("single strobe k=%0d", k), rd_valid, (k == 13));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule